// File: doc/BRIEF.md
# Width-Packing DMA Channel Byte FIFO

This block is the data buffer of one DMA channel. The source side pushes units of one, two or four bytes and the destination side pops units of one, two or four bytes, each side with its own width code. The buffer keeps a precise byte count, so a narrow source can fill a wide destination word over several pushes, and a wide source word can be drained over several narrow pops. Bytes are packed and unpacked little-endian: the first byte stored is the lowest byte lane of the word that carries it.

The empty flag reports that the bytes held cannot make up one destination unit. It can be high while residual bytes remain. A flush input drops every held byte in one cycle. The channel controller asserts it when the channel is disabled, so leftovers are never delivered and are not seen when the channel is enabled again. While a channel is suspended, the controller simply stops pushing, and the destination drains whole units until empty rises.

Top module: `dma_pack_fifo`

## Requirements
- R1: Reset and flush leave the FIFO in the same state: `empty`=1, `full`=0, `pop_valid`=0, no bytes held. After reset, popped data comes only from pushes made after reset.
- R2: Width codes apply to both `src_width` and `dst_width`: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. With a narrow source and a wide destination, successive pushes are packed little-endian. For example, four byte pushes 11,22,33,44 pop as 32'h44332211.
- R3: `empty` is high whenever the byte count is below the destination unit size, even with 1 to 3 residual bytes held. It goes low in the cycle after the push that completes a unit.
- R4: With a wide source and a narrow destination, one source word is split into successive pops from the lowest byte lane upward. Popped data sits in the low lanes and unused upper lanes read as zero.
- R5: A push is accepted only when the free space (capacity `DEPTH`=16 bytes) is at least the source unit size. `full` (and `push_ready`=0) shows this against the current `src_width`. A refused push stores nothing.
- R6: A pop request while `empty` is high is ignored: `pop_valid` stays 0 and no bytes are consumed.
- R7: `flush` discards all held bytes. The next data popped after a flush is made only of bytes pushed after it.
- R8: `flush` takes priority over a push or pop in the same cycle: neither is performed and `pop_valid` is 0 in the next cycle.
- R9: A push and a pop in the same cycle both take effect.
- R10: An accepted pop returns its data on `pop_data` with `pop_valid`=1 in the cycle after the request. `pop_valid` is 0 in cycles after no accepted pop.
- R11: Storage is circular, so byte order is kept across the wrap from the last byte slot back to the first. Width code 3 is treated as 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_width | input | 2 | Source unit width code |
| dst_width | input | 2 | Destination unit width code |
| flush | input | 1 | Drop all held bytes (channel disable) |
| push_valid | input | 1 | Push request |
| push_data | input | 32 | Push data, valid bytes in the low lanes |
| push_ready | output | 1 | Push would be accepted (not full) |
| pop_req | input | 1 | Pop request |
| pop_valid | output | 1 | Registered: pop_data holds a popped unit |
| pop_data | output | 32 | Registered popped unit, zero-extended |
| empty | output | 1 | Too few bytes for one destination unit |
| full | output | 1 | Too little space for one source unit |

## Verification
The bench stops at the residual point where three bytes are held against a word destination. A design that tested for zero bytes would drop `empty` too early and pop a torn word. Units are also placed across the storage wrap, where a pointer that did not wrap per byte would scramble lane order. A flush is issued together with a push and a pop, which catches a design that stores the pushed byte or lets stale leftovers reach the next word. The bench also checks `full` against two source widths at the same fill of 15 bytes, which exposes a full flag computed from the byte count alone.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  localparam int LANES = 4;

  // Width code to unit size in bytes; code 3 is treated as a word.
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dpf_byte_store.sv
module dpf_byte_store #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [PTR_W-1:0]   wptr,
  input  logic [2:0]         wcount,
  input  logic [8*LANES-1:0] wdata,
  input  logic [PTR_W-1:0]   rptr,
  output logic [8*LANES-1:0] rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && (3'(l) < wcount))
        mem[PTR_W'(wptr + PTR_W'(l))] <= wdata[8*l +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rdata[8*g +: 8] = mem[PTR_W'(rptr + PTR_W'(g))];
  end
endmodule

// File: rtl/dpf_level_ctrl.sv
module dpf_level_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push_valid,
  input  logic             pop_req,
  input  logic [2:0]       sbytes,
  input  logic [2:0]       dbytes,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [OCC_W-1:0] occ,
  output logic             push_fire,
  output logic             pop_fire,
  output logic             empty,
  output logic             full
);
  logic [OCC_W-1:0] free_bytes;
  logic [OCC_W-1:0] add_n, sub_n;

  assign free_bytes = OCC_W'(DEPTH) - occ;
  assign full       = free_bytes < OCC_W'(sbytes);
  assign empty      = occ < OCC_W'(dbytes);
  assign push_fire  = push_valid && !full && !flush;
  assign pop_fire   = pop_req && !empty && !flush;
  assign add_n      = push_fire ? OCC_W'(sbytes) : '0;
  assign sub_n      = pop_fire  ? OCC_W'(dbytes) : '0;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push_fire) wptr <= PTR_W'(wptr + PTR_W'(sbytes));
      if (pop_fire)  rptr <= PTR_W'(rptr + PTR_W'(dbytes));
      occ <= occ + add_n - sub_n;
    end
  end
endmodule

// File: rtl/dpf_lane_pack.sv
module dpf_lane_pack #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] raw,
  input  logic [2:0]         nbytes,
  output logic [8*LANES-1:0] packed_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign packed_out[8*g +: 8] = (3'(g) < nbytes) ? raw[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo #(
  parameter int DEPTH = 16,
  localparam int LANES = dpf_pkg::LANES,
  localparam int DW    = 8 * LANES,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    src_width,
  input  logic [1:0]    dst_width,
  input  logic          flush,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop_req,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          empty,
  output logic          full
);
  logic [2:0]       sbytes, dbytes;
  logic [PTR_W-1:0] wptr, rptr;
  logic [OCC_W-1:0] occ;
  logic             push_fire, pop_fire;
  logic [DW-1:0]    rd_raw, rd_masked;

  assign sbytes = dpf_pkg::unit_bytes(src_width);
  assign dbytes = dpf_pkg::unit_bytes(dst_width);

  dpf_level_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid),
    .pop_req(pop_req), .sbytes(sbytes), .dbytes(dbytes),
    .wptr(wptr), .rptr(rptr), .occ(occ), .push_fire(push_fire),
    .pop_fire(pop_fire), .empty(empty), .full(full)
  );

  dpf_byte_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk(clk), .we(push_fire), .wptr(wptr), .wcount(sbytes),
    .wdata(push_data), .rptr(rptr), .rdata(rd_raw)
  );

  dpf_lane_pack #(.LANES(LANES)) u_pack (
    .raw(rd_raw), .nbytes(dbytes), .packed_out(rd_masked)
  );

  assign push_ready = !full;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pop_valid <= 1'b0;
      pop_data  <= '0;
    end else begin
      pop_valid <= pop_fire;
      if (pop_fire) pop_data <= rd_masked;
    end
  end
endmodule

// File: rtl/dma_pack_fifo_chk.sv
module dma_pack_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             push_valid,
  input logic             push_ready,
  input logic             pop_req,
  input logic             pop_valid,
  input logic             empty,
  input logic             full,
  input logic [OCC_W-1:0] occ
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (empty && !full && !pop_valid));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));

  a_r5_refused_push: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready && !pop_req && !flush) |=> occ == $past(occ));

  a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    (pop_req && empty) |=> !pop_valid);

  a_r8_flush_wins: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0 && empty && !pop_valid));

  a_r10_pop_pulse: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !empty && !flush) |=> pop_valid);
endmodule

bind dma_pack_fifo dma_pack_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid),
  .push_ready(push_ready), .pop_req(pop_req), .pop_valid(pop_valid),
  .empty(empty), .full(full), .occ(occ)
);

// File: tb/sim_dma_pack_fifo.sv
module sim_dma_pack_fifo;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  src_width, dst_width;
  logic        flush, push_valid, pop_req;
  logic [31:0] push_data;
  logic        push_ready, pop_valid, empty, full;
  logic [31:0] pop_data;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  dma_pack_fifo u0 (
    .clk(clk), .rst(rst), .src_width(src_width), .dst_width(dst_width),
    .flush(flush), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .pop_req(pop_req), .pop_valid(pop_valid),
    .pop_data(pop_data), .empty(empty), .full(full)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  s, d;
    logic        pv;
    logic [31:0] pd;
    logic        pr, fl, xpv;
    logic [31:0] xpd;
    logic        xe, xf;
  } vec_t;

  function automatic vec_t mk(input int req, input int s, input int d,
      input bit pv, input logic [31:0] pd, input bit pr, input bit fl,
      input bit xpv, input logic [31:0] xpd, input bit xe, input bit xf);
    mk = '{4'(req), 2'(s), 2'(d), pv, pd, pr, fl, xpv, xpd, xe, xf};
  endfunction

  // Each row: inputs for one cycle, outputs expected after that edge.
  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    mk(11,0,0,1,32'h5A,0,0, 0,0,0,0),            // R11 offset pointers by 1
    mk(10,0,0,0,0,1,0, 1,32'h5A,1,0),            // R10
    mk(2,0,2,1,32'h11,0,0, 0,0,1,0),             // R2 byte into word
    mk(3,0,2,1,32'h22,0,0, 0,0,1,0),             // R3 residual
    mk(3,0,2,1,32'h33,0,0, 0,0,1,0),             // R3 3 bytes still empty
    mk(3,0,2,1,32'h44,0,0, 0,0,0,0),             // R3 unit complete
    mk(2,0,2,0,0,1,0, 1,32'h44332211,1,0),       // R2 packed word
    mk(4,2,0,1,32'hAABBCCDD,0,0, 0,0,0,0),       // R4
    mk(4,2,0,0,0,1,0, 1,32'hDD,0,0),
    mk(4,2,0,0,0,1,0, 1,32'hCC,0,0),
    mk(4,2,0,0,0,1,0, 1,32'hBB,0,0),
    mk(4,2,0,0,0,1,0, 1,32'hAA,1,0),
    mk(6,2,0,0,0,1,0, 0,0,1,0),                  // R6 pop while empty
    mk(9,1,2,1,32'h1234,0,0, 0,0,1,0),
    mk(9,1,2,1,32'h5678,0,0, 0,0,0,0),
    mk(9,1,2,1,32'h9ABC,1,0, 1,32'h56781234,1,0),// R9 push+pop
    mk(9,1,2,1,32'hDEF0,0,0, 0,0,0,0),
    mk(11,1,2,0,0,1,0, 1,32'hDEF09ABC,1,0),      // R11 word across wrap
    mk(5,2,2,1,32'h11111111,0,0, 0,0,0,0),
    mk(5,2,2,1,32'h22222222,0,0, 0,0,0,0),
    mk(5,2,2,1,32'h33333333,0,0, 0,0,0,0),
    mk(5,2,2,1,32'h44444444,0,0, 0,0,0,1),       // R5 full at 16
    mk(5,2,2,1,32'hEEEEEEEE,0,0, 0,0,0,1),       // R5 refused push
    mk(5,2,2,0,0,1,0, 1,32'h11111111,0,0),
    mk(5,2,2,0,0,1,0, 1,32'h22222222,0,0),
    mk(5,2,2,0,0,1,0, 1,32'h33333333,0,0),
    mk(5,2,2,0,0,1,0, 1,32'h44444444,1,0),       // R5 refused data absent
    mk(7,0,2,1,32'h55,0,0, 0,0,1,0),
    mk(7,0,2,1,32'h66,0,0, 0,0,1,0),
    mk(8,0,2,1,32'h77,1,1, 0,0,1,0),             // R8 flush wins
    mk(7,0,2,1,32'h01,0,0, 0,0,1,0),
    mk(7,0,2,1,32'h02,0,0, 0,0,1,0),
    mk(7,0,2,1,32'h03,0,0, 0,0,1,0),
    mk(7,0,2,1,32'h04,0,0, 0,0,0,0),
    mk(7,0,2,0,0,1,0, 1,32'h04030201,1,0)        // R7 no leftovers
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive one cycle's inputs at a falling edge, return at the next one.
  task automatic step(input int s, input int d, input bit pv, input logic [31:0] pd,
                      input bit pr, input bit fl);
    src_width = 2'(s); dst_width = 2'(d); push_valid = pv; push_data = pd;
    pop_req = pr; flush = fl;
    @(negedge clk);
    push_valid = 0; pop_req = 0; flush = 0;
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; src_width = 0; dst_width = 0; flush = 0;
    push_valid = 0; pop_req = 0; push_data = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset empty", 32'(empty), 1);
    chk("R1 reset full", 32'(full), 0);
    chk("R1 reset pop_valid", 32'(pop_valid), 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      step(VEC[i].s, VEC[i].d, VEC[i].pv, VEC[i].pd, VEC[i].pr, VEC[i].fl);
      chk({tag, " pop_valid"}, 32'(pop_valid), 32'(VEC[i].xpv));
      if (VEC[i].xpv) chk({tag, " pop_data"}, pop_data, VEC[i].xpd);
      chk({tag, " empty"}, 32'(empty), 32'(VEC[i].xe));
      chk({tag, " full"}, 32'(full), 32'(VEC[i].xf));
    end

    // R11: width code 3 acts as a word
    step(3, 3, 1, 32'hCAFEF00D, 0, 0);
    chk("R11 code3 empty", 32'(empty), 0);
    step(3, 3, 0, 0, 1, 0);
    chk("R11 code3 data", pop_data, 32'hCAFEF00D);
    chk("R11 code3 drained", 32'(empty), 1);

    // R5: full depends on source width at 15 bytes held
    for (int i = 0; i < 3; i++) step(2, 2, 1, 32'hA1A1A1A1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 2, 1, 32'hB2, 0, 0);
    chk("R5 15 bytes byte src full", 32'(full), 0);
    src_width = 2'd1; #1;
    chk("R5 15 bytes half src full", 32'(full), 1);
    chk("R5 15 bytes half src ready", 32'(push_ready), 0);
    @(negedge clk);
    step(0, 2, 1, 32'hB2, 0, 0);
    chk("R5 16 bytes full", 32'(full), 1);
    // R7: flush clears everything
    step(0, 2, 0, 0, 0, 1);
    chk("R7 flush empty", 32'(empty), 1);
    chk("R7 flush full", 32'(full), 0);
    step(2, 2, 1, 32'hBEEF0001, 0, 0);
    step(2, 2, 0, 0, 1, 0);
    chk("R7 fresh data after flush", pop_data, 32'hBEEF0001);

    // R1: reset in mid-stream drops held data
    step(2, 2, 1, 32'h12345678, 0, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 midreset empty", 32'(empty), 1);
    chk("R1 midreset full", 32'(full), 0);
    chk("R1 midreset pop_valid", 32'(pop_valid), 0);
    step(2, 2, 1, 32'h0A0B0C0D, 0, 0);
    step(2, 2, 0, 0, 1, 0);
    chk("R1 data after reset", pop_data, 32'h0A0B0C0D);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule